// File: doc/BRIEF.md
# Reset Cause Recorder with Keyed Watchdog

This block keeps a one-byte record of why the system last went through reset and runs a watchdog timer that software services through the same bus address. Each reset source arrives as a level input. A single-cycle reset-entry pulse tells the block to take a snapshot of those levels. The snapshot follows fixed precedence rules. A debug-forced reset clears everything. A power-on reset sets a fixed pattern. A low-voltage reset keeps the earlier power-on flag. Any other reset copies each active source into its flag.

Software can only read the byte. Writes to the address form the watchdog service port. Writing 0x55 and then 0xAA restarts the timeout counter. Any other written value makes the block request a watchdog reset at once. A 2-bit timeout select sets the period to one of three powers of two, and the code 00 turns the watchdog off. A watchdog request is held internally until the next reset entry, where it shows up as the watchdog flag.

Top module: `rstcause_wdog`

## Requirements
- R1: The status byte places the flags as follows: bit 7 power-on, bit 6 external pin, bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal address, bit 1 low-voltage. Bits 2 and 0 always read 0. `busRdData` is 0 when `busSel` is low. After `hwRstN` the byte reads 0x00.
- R2: A reset entry with `srcPowerOn` high and `srcDebug` low loads 0x82, whatever the other sources are.
- R3: A reset entry with `srcLowVolt` high, and with both `srcPowerOn` and `srcDebug` low, keeps the previous power-on flag, sets bit 1 and clears all other flags.
- R4: Any other reset entry (no debug, power-on or low-voltage source) loads each of the pin, illegal-opcode and illegal-address flags from its source level. It loads the watchdog flag from the pending watchdog request and clears the power-on and low-voltage flags.
- R5: A reset entry with `srcDebug` high loads 0x00 and discards any pending watchdog request.
- R6: A write of 0x55 followed directly by a write of 0xAA restarts the timeout count at the 0xAA write edge, with no request. The next timeout then comes a full period after that edge.
- R7: While `wdogSel` is not 00, a write of any value other than 0x55 or 0xAA drives `wdogReq` high in the cycle after the write edge.
- R8: While `wdogSel` is 00, `wdogReq` stays low: there are no timeouts and no bad-write requests.
- R9: Bus writes never change the status byte. Only a reset entry changes it.
- R10: A 0xAA write not directly preceded by a 0x55 write, or a second 0x55 write, neither restarts the count nor raises a request.
- R11: With no servicing, `wdogReq` rises 2^5, 2^8 or 2^10 edges after the count restart for `wdogSel` codes 01, 10 and 11. It stays high for exactly one cycle.
- R12: After a watchdog request, the next reset entry sets bit 5, and the count restarts from zero at that entry edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| hwRstN | input | 1 | Asynchronous hardware initialisation, active low |
| busSel | input | 1 | Address decode hit for the status/service address |
| busWr | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, status byte when selected |
| wdogSel | input | 2 | Timeout select, 00 disables the watchdog |
| srcPowerOn | input | 1 | Power-on detector level |
| srcPin | input | 1 | External reset pin active level |
| srcLowVolt | input | 1 | Low-voltage detector level |
| srcIllegalOp | input | 1 | Illegal opcode detected level |
| srcIllegalAddr | input | 1 | Illegal address detected level |
| srcDebug | input | 1 | Debug-host forced reset level |
| resetEntry | input | 1 | One-cycle pulse marking reset entry |
| wdogReq | output | 1 | One-cycle watchdog reset request |

## Verification
Several properties are checked by assertions on every cycle:
- The reserved read bits and the idle read value stay zero.
- The status byte stays unchanged outside reset entry.
- The power-on and debug snapshots have fixed values.
- A bad write raises a request.
- A disabled watchdog stays quiet.
- The request lasts one cycle.

Some behaviours can only be shown by the bench's scenarios, because they depend on history over hundreds of cycles. These are the exact timeout distance for each select code, the effect of a correct key versus a broken key sequence on that distance, the retention of the power-on flag across a low-voltage reset, and the watchdog flag appearing at the reset after a request.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef struct packed {
    logic por;
    logic pin;
    logic wdog;
    logic illOp;
    logic illAddr;
    logic lowVolt;
  } causeFlags_t;

  typedef struct packed {
    logic capture;
    logic cntClr;
    logic armSet;
    logic armClr;
    logic fireReq;
  } wdStrobe_t;

  function automatic logic [7:0] packStatus(causeFlags_t f);
    return {f.por, f.pin, f.wdog, f.illOp, f.illAddr, 1'b0, f.lowVolt, 1'b0};
  endfunction

endpackage

// File: rtl/rstcause_ctrl.sv
module rstcause_ctrl
  import rstcause_pkg::*;
(
  input  logic       busSel,
  input  logic       busWr,
  input  logic [7:0] busWrData,
  input  logic [1:0] wdogSel,
  input  logic       resetEntry,
  input  logic       armed,
  input  logic       atLimit,
  output wdStrobe_t  strobe
);

  logic enabled;
  logic wrHit;
  logic isArm;
  logic isFire;
  logic kick;
  logic badWr;

  always_comb begin
    enabled = (wdogSel != 2'b00);
    wrHit   = busSel & busWr;
    isArm   = (busWrData == KEY_ARM);
    isFire  = (busWrData == KEY_FIRE);
    kick    = wrHit & isFire & armed;
    badWr   = wrHit & ~isArm & ~isFire;

    strobe.capture = resetEntry;
    strobe.cntClr  = ~enabled | kick;
    strobe.fireReq = enabled & (badWr | (atLimit & ~kick));
    strobe.armSet  = enabled & wrHit & isArm;
    strobe.armClr  = ~enabled | (wrHit & ~isArm);
  end

endmodule

// File: rtl/rstcause_dp.sv
module rstcause_dp
  import rstcause_pkg::*;
#(
  parameter int SHORT_LOG2 = 5,
  parameter int MID_LOG2   = 8,
  parameter int LONG_LOG2  = 10
) (
  input  logic        clk,
  input  logic        hwRstN,
  input  wdStrobe_t   strobe,
  input  logic [1:0]  wdogSel,
  input  logic        srcPowerOn,
  input  logic        srcPin,
  input  logic        srcLowVolt,
  input  logic        srcIllegalOp,
  input  logic        srcIllegalAddr,
  input  logic        srcDebug,
  output logic        armed,
  output logic        atLimit,
  output logic        wdogReq,
  output causeFlags_t flagsQ
);

  localparam int CNT_W = LONG_LOG2;
  localparam int NUM_CODES = 4;

  logic [CNT_W-1:0] cntQ;
  logic             pendingQ;
  causeFlags_t      flagsNext;
  logic [CNT_W-1:0] limTab [NUM_CODES];

  // Terminal count per select code; code 0 is never compared (disabled).
  for (genvar g = 0; g < NUM_CODES; g++) begin : gLim
    localparam int LOG2 = (g == 1) ? SHORT_LOG2 : (g == 2) ? MID_LOG2 : LONG_LOG2;
    if (g == 0) begin : gOff
      assign limTab[g] = '0;
    end else begin : gOn
      assign limTab[g] = CNT_W'((64'd1 << LOG2) - 64'd1);
    end
  end

  assign atLimit = (wdogSel != 2'b00) && (cntQ == limTab[wdogSel]);

  always_comb begin
    flagsNext = '0;
    if (srcDebug) begin
      flagsNext = '0;
    end else if (srcPowerOn) begin
      flagsNext.por     = 1'b1;
      flagsNext.lowVolt = 1'b1;
    end else if (srcLowVolt) begin
      flagsNext.por     = flagsQ.por;
      flagsNext.lowVolt = 1'b1;
    end else begin
      flagsNext.pin     = srcPin;
      flagsNext.wdog    = pendingQ;
      flagsNext.illOp   = srcIllegalOp;
      flagsNext.illAddr = srcIllegalAddr;
    end
  end

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      flagsQ   <= '0;
      cntQ     <= '0;
      armed    <= 1'b0;
      wdogReq  <= 1'b0;
      pendingQ <= 1'b0;
    end else if (strobe.capture) begin
      flagsQ   <= flagsNext;
      cntQ     <= '0;
      armed    <= 1'b0;
      wdogReq  <= 1'b0;
      pendingQ <= 1'b0;
    end else begin
      wdogReq <= strobe.fireReq;
      if (strobe.fireReq) pendingQ <= 1'b1;
      if (strobe.cntClr || strobe.fireReq) cntQ <= '0;
      else                                 cntQ <= cntQ + 1'b1;
      if (strobe.armSet)      armed <= 1'b1;
      else if (strobe.armClr) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/rstcause_wdog.sv
module rstcause_wdog
  import rstcause_pkg::*;
#(
  parameter int SHORT_LOG2 = 5,
  parameter int MID_LOG2   = 8,
  parameter int LONG_LOG2  = 10
) (
  input  logic       clk,
  input  logic       hwRstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic [1:0] wdogSel,
  input  logic       srcPowerOn,
  input  logic       srcPin,
  input  logic       srcLowVolt,
  input  logic       srcIllegalOp,
  input  logic       srcIllegalAddr,
  input  logic       srcDebug,
  input  logic       resetEntry,
  output logic       wdogReq
);

  wdStrobe_t   strobe;
  causeFlags_t flagsQ;
  logic        armed;
  logic        atLimit;
  logic [7:0]  statusQ;

  rstcause_ctrl u_ctrl (
    .busSel     (busSel),
    .busWr      (busWr),
    .busWrData  (busWrData),
    .wdogSel    (wdogSel),
    .resetEntry (resetEntry),
    .armed      (armed),
    .atLimit    (atLimit),
    .strobe     (strobe)
  );

  rstcause_dp #(
    .SHORT_LOG2 (SHORT_LOG2),
    .MID_LOG2   (MID_LOG2),
    .LONG_LOG2  (LONG_LOG2)
  ) u_dp (
    .clk            (clk),
    .hwRstN         (hwRstN),
    .strobe         (strobe),
    .wdogSel        (wdogSel),
    .srcPowerOn     (srcPowerOn),
    .srcPin         (srcPin),
    .srcLowVolt     (srcLowVolt),
    .srcIllegalOp   (srcIllegalOp),
    .srcIllegalAddr (srcIllegalAddr),
    .srcDebug       (srcDebug),
    .armed          (armed),
    .atLimit        (atLimit),
    .wdogReq        (wdogReq),
    .flagsQ         (flagsQ)
  );

  assign statusQ   = packStatus(flagsQ);
  assign busRdData = busSel ? statusQ : 8'h00;

endmodule

// File: rtl/rstcause_chk.sv
module rstcause_chk (
  input logic       clk,
  input logic       hwRstN,
  input logic       busSel,
  input logic       busWr,
  input logic [7:0] busWrData,
  input logic [7:0] busRdData,
  input logic [1:0] wdogSel,
  input logic       srcPowerOn,
  input logic       srcDebug,
  input logic       resetEntry,
  input logic       wdogReq,
  input logic [7:0] statusQ
);

  AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (!hwRstN)
    busRdData[2] == 1'b0 && busRdData[0] == 1'b0); // R1

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!hwRstN)
    !busSel |-> busRdData == 8'h00); // R1

  AST_POR_SNAPSHOT: assert property (@(posedge clk) disable iff (!hwRstN)
    resetEntry && srcPowerOn && !srcDebug |=> statusQ == 8'h82); // R2

  AST_DEBUG_CLEARS: assert property (@(posedge clk) disable iff (!hwRstN)
    resetEntry && srcDebug |=> statusQ == 8'h00); // R5

  AST_BAD_WRITE_FIRES: assert property (@(posedge clk) disable iff (!hwRstN)
    busSel && busWr && wdogSel != 2'b00 && busWrData != 8'h55 &&
    busWrData != 8'hAA && !resetEntry |=> wdogReq); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!hwRstN)
    wdogSel == 2'b00 |=> !wdogReq); // R8

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!hwRstN)
    !resetEntry |=> $stable(statusQ)); // R9

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!hwRstN)
    wdogReq && !busWr |=> !wdogReq); // R11

endmodule

bind rstcause_wdog rstcause_chk u_chk (.*);

// File: tb/sim_rstcause_wdog.sv
`timescale 1ns/1ps
module sim_rstcause_wdog;

  logic       clk = 1'b0;
  logic       hwRstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic [1:0] wdogSel = 2'b00;
  logic       srcPowerOn = 1'b0;
  logic       srcPin = 1'b0;
  logic       srcLowVolt = 1'b0;
  logic       srcIllegalOp = 1'b0;
  logic       srcIllegalAddr = 1'b0;
  logic       srcDebug = 1'b0;
  logic       resetEntry = 1'b0;
  logic       wdogReq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rstcause_wdog u0 (
    .clk(clk), .hwRstN(hwRstN), .busSel(busSel), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .wdogSel(wdogSel),
    .srcPowerOn(srcPowerOn), .srcPin(srcPin), .srcLowVolt(srcLowVolt),
    .srcIllegalOp(srcIllegalOp), .srcIllegalAddr(srcIllegalAddr),
    .srcDebug(srcDebug), .resetEntry(resetEntry), .wdogReq(wdogReq)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic setSrc(bit po, bit pn, bit lv, bit io, bit ia, bit db);
    srcPowerOn = po; srcPin = pn; srcLowVolt = lv;
    srcIllegalOp = io; srcIllegalAddr = ia; srcDebug = db;
  endtask

  task automatic pulseEntry(output int edgeCyc);
    @(negedge clk); resetEntry = 1'b1;
    @(posedge clk); #1 edgeCyc = cyc;
    @(negedge clk); resetEntry = 1'b0;
    setSrc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic readStatus(output logic [7:0] val);
    @(negedge clk); busSel = 1'b1; busWr = 1'b0;
    #1 val = busRdData;
    busSel = 1'b0;
  endtask

  task automatic writeBus(logic [7:0] d, output int edgeCyc);
    @(negedge clk); busSel = 1'b1; busWr = 1'b1; busWrData = d;
    @(posedge clk); #1 edgeCyc = cyc;
    @(negedge clk); busSel = 1'b0; busWr = 1'b0; busWrData = 8'h00;
  endtask

  task automatic waitReq(output int reqCyc);
    reqCyc = -1;
    for (int i = 0; i < 1200; i++) begin
      @(posedge clk); #1;
      if (wdogReq) begin reqCyc = cyc; break; end
    end
  endtask

  task automatic entryExpect(string tag, logic [7:0] exp);
    int e;
    logic [7:0] v;
    pulseEntry(e);
    readStatus(v);
    check(tag, v, exp);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    readStatus(v);
    check("R1 reset value", v, 8'h00);
    @(negedge clk); #1;
    check("R1 unselected read", busRdData, 8'h00);
  endtask

  task automatic t_sources();
    setSrc(1, 1, 0, 1, 0, 0); entryExpect("R2 power-on", 8'h82);
    setSrc(0, 1, 1, 0, 1, 0); entryExpect("R3 low-volt keeps por", 8'h82);
    setSrc(0, 1, 0, 0, 0, 0); entryExpect("R4 pin only", 8'h40);
    setSrc(0, 0, 1, 0, 0, 0); entryExpect("R3 low-volt por clear", 8'h02);
    setSrc(0, 1, 0, 1, 0, 0); entryExpect("R4 pin+illop", 8'h50);
    setSrc(0, 0, 0, 0, 1, 0); entryExpect("R4 illaddr", 8'h08);
    setSrc(1, 1, 1, 1, 1, 1); entryExpect("R5 debug clears", 8'h00);
  endtask

  task automatic t_timeout(logic [1:0] code, int len);
    int e, r;
    logic [7:0] v;
    wdogSel = code;
    pulseEntry(e);
    waitReq(r);
    check($sformatf("R11 timeout distance code %0d", code), r - e, len);
    @(posedge clk); #1;
    check("R11 request one cycle", wdogReq, 0);
    entryExpect("R12 watchdog flag", 8'h20);
    readStatus(v);
  endtask

  task automatic t_kick();
    int e, w, k, r;
    logic [7:0] v;
    wdogSel = 2'b01;
    pulseEntry(e);
    repeat (10) @(negedge clk);
    writeBus(8'h55, w);
    repeat (5) @(negedge clk);
    writeBus(8'hAA, k);
    check("R6 no request on key", wdogReq, 0);
    readStatus(v);
    check("R9 key keeps status", v, 8'h00);
    waitReq(r);
    check("R6 restart at key edge", r - k, 32);
    entryExpect("R12 flag after kicked timeout", 8'h20);
  endtask

  task automatic t_brokenKey();
    int e, w, r;
    wdogSel = 2'b01;
    pulseEntry(e);
    repeat (4) @(negedge clk);
    writeBus(8'hAA, w);
    check("R10 lone AA no request", wdogReq, 0);
    waitReq(r);
    check("R10 lone AA no restart", r - e, 32);
    pulseEntry(e);
    writeBus(8'h55, w);
    writeBus(8'h55, w);
    check("R10 double 55 no request", wdogReq, 0);
    waitReq(r);
    check("R10 double 55 no restart", r - e, 32);
    entryExpect("R12 flag after broken key", 8'h20);
  endtask

  task automatic t_badWrite();
    int e, w, r;
    logic [7:0] v;
    wdogSel = 2'b01;
    pulseEntry(e);
    repeat (3) @(negedge clk);
    writeBus(8'h12, w);
    check("R7 bad write request", wdogReq, 1);
    readStatus(v);
    check("R9 bad write keeps status", v, 8'h00);
    check("R7 request one cycle", wdogReq, 0);
    pulseEntry(e);
    readStatus(v);
    check("R12 flag after bad write", v, 8'h20);
    waitReq(r);
    check("R12 count restarts at entry", r - e, 32);
    entryExpect("R12 flag again", 8'h20);
  endtask

  task automatic t_disabled();
    int e, w;
    int seen = 0;
    logic [7:0] v;
    wdogSel = 2'b00;
    pulseEntry(e);
    writeBus(8'h12, w);
    if (wdogReq) seen++;
    writeBus(8'hAA, w);
    for (int i = 0; i < 1100; i++) begin
      @(posedge clk); #1;
      if (wdogReq) seen++;
    end
    check("R8 disabled never requests", seen, 0);
    readStatus(v);
    check("R9 disabled writes keep status", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); hwRstN = 1'b1;
    t_reset();
    t_sources();
    t_timeout(2'b01, 32);
    t_timeout(2'b10, 256);
    t_timeout(2'b11, 1024);
    t_kick();
    t_brokenKey();
    t_badWrite();
    t_disabled();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule